// File: doc/BRIEF.md
# Register Job Request Master

This block lets a local controller run single-register read and write jobs against a small byte-register target. The target sits at the far end of two framed byte links. A one-cycle command pulse starts a job. It carries a read/write select, a register address and, for writes, one data byte. The master builds the request frame and presents it on the outgoing link. Each beat is held until the target accepts it. The master then takes the acknowledge frame that comes back.

The first request beat is a header byte. Its upper half holds the address and its lower half holds a command code. A read is one beat. A write is two beats: the header, then the data byte. Every acknowledge starts with an echoed header and ends with a status footer. A read acknowledge also carries one data beat between the two. When the footer arrives, the master reports completion, the returned byte for reads and an error indication. Only one job is in flight at a time. Command pulses that arrive during a job are dropped.

Top module: `regjob_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `busy`, `done`, `err`, `rd_data`, `rq_valid`, `rq_first`, `rq_last`, `rq_data` and `ak_ready` are all zero.
- R2: The request header byte carries the address in bits 7..4 and the command code in bits 3..0. Code 0 is read and code 1 is write.
- R3: A read request is a single beat with `rq_first` and `rq_last` both set, carrying the header.
- R4: A write request is two beats. The header beat has `rq_first` set and `rq_last` clear. The next beat has `rq_first` clear and `rq_last` set, and carries the write byte.
- R5: While `rq_valid` is high and `rq_ready` is low, `rq_valid`, `rq_first`, `rq_last` and `rq_data` stay unchanged in the next cycle.
- R6: `ak_ready` goes high in the cycle after the last request beat is accepted. It stays high until the footer is taken, and it is low at all other times, including while a request beat is pending.
- R7: An acknowledge beat with neither `ak_first` nor `ak_last` set (the read data beat) is copied into `rd_data`. A write job leaves `rd_data` unchanged.
- R8: In the cycle after a footer beat (`ak_last` set) is accepted, `done` is high for exactly one cycle, `busy` is low, and `err` equals bit 0 of the footer byte. Footer 0x00 means success and 0x01 means error.
- R9: A `cmd_go` pulse while `busy` is high is ignored. The job in flight is unaffected and no further request follows it.
- R10: In the cycle after an accepted `cmd_go`, `busy` is high and the header beat is on the request link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_go | input | 1 | One-cycle job start pulse |
| cmd_wr | input | 1 | 1 = write job, 0 = read job |
| cmd_addr | input | 4 | Target register address |
| cmd_wdata | input | 8 | Byte to write |
| busy | output | 1 | A job is in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| err | output | 1 | Bit 0 of the last footer |
| rq_data | output | 8 | Request link byte |
| rq_valid | output | 1 | Request beat present |
| rq_first | output | 1 | Request beat is the header |
| rq_last | output | 1 | Request beat ends the frame |
| rq_ready | input | 1 | Target takes the request beat |
| ak_data | input | 8 | Acknowledge link byte |
| ak_valid | input | 1 | Acknowledge beat present |
| ak_first | input | 1 | Acknowledge beat is the echoed header |
| ak_last | input | 1 | Acknowledge beat is the footer |
| ak_ready | output | 1 | Master takes acknowledge beats |

## Verification
The hardest case to reach from the ports is a second command arriving mid-job, while a request beat is stalled. The bench drives `cmd_go` with a different address while the target model holds `rq_ready` low. It then confirms that the stalled header keeps its original value. After the footer it watches the request link for several idle cycles to show that no phantom job starts. Stalls on the request side and gaps between acknowledge beats are also mixed in, so that the hold rule and the phase boundary of `ak_ready` are exercised.

// File: rtl/regjob_pkg.sv
// Shared constants and types for the register job master.
// Assumes the header byte is {address, command} with the command in the low bits.
package regjob_pkg;

    // Command codes carried in the low field of a header byte.
    localparam int CMD_READ  = 0;
    localparam int CMD_WRITE = 1;

    // Request framer states.
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HDR  = 2'd1,
        TX_DATA = 2'd2
    } tx_state_t;

endpackage

// File: rtl/regjob_req_tx.sv
// Request framer: sends one header beat for a read, or header plus data beat
// for a write, holding each beat until the target accepts it.
// Assumes start is only pulsed while the framer is idle.
module regjob_req_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_wr,
    input  logic [DATA_W-1:0] hdr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rq_data,
    output logic              rq_valid,
    output logic              rq_first,
    output logic              rq_last,
    input  logic              rq_ready,
    output logic              sent
);
    import regjob_pkg::*;

    tx_state_t         state;
    logic [DATA_W-1:0] wbuf;
    logic              wr_q;

    // Pulses when the closing beat of the request frame is taken.
    assign sent = rq_valid & rq_ready & rq_last;

    // Beat sequencing and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            wbuf     <= '0;
            wr_q     <= 1'b0;
            rq_data  <= '0;
            rq_valid <= 1'b0;
            rq_first <= 1'b0;
            rq_last  <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        rq_valid <= 1'b1;
                        rq_data  <= hdr;
                        rq_first <= 1'b1;
                        rq_last  <= !is_wr;
                        wbuf     <= wdata;
                        wr_q     <= is_wr;
                        state    <= TX_HDR;
                    end
                end
                TX_HDR: begin
                    if (rq_ready) begin
                        if (wr_q) begin
                            rq_data  <= wbuf;
                            rq_first <= 1'b0;
                            rq_last  <= 1'b1;
                            state    <= TX_DATA;
                        end else begin
                            rq_valid <= 1'b0;
                            rq_first <= 1'b0;
                            rq_last  <= 1'b0;
                            rq_data  <= '0;
                            state    <= TX_IDLE;
                        end
                    end
                end
                TX_DATA: begin
                    if (rq_ready) begin
                        rq_valid <= 1'b0;
                        rq_first <= 1'b0;
                        rq_last  <= 1'b0;
                        rq_data  <= '0;
                        state    <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // A pending beat must not move until it is accepted.
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid && !rq_ready |=> rq_valid && $stable(rq_data)
                                  && $stable(rq_first) && $stable(rq_last));

    // Every request beat is framed: header, closing beat, or both.
    p_req_framed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |-> (rq_first || rq_last));

    // Flags never show without a valid beat.
    p_req_flags_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rq_valid |-> !rq_first && !rq_last);

    // A write header is always followed by its data beat.
    p_wr_second_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid && rq_first && !rq_last && rq_ready |=> rq_valid && !rq_first && rq_last);

endmodule

// File: rtl/regjob_ack_rx.sv
// Acknowledge parser: once armed, accepts beats every cycle, keeps the data
// beat of a read and ends the job on the footer.
// Assumes the target frames acknowledges correctly; the header echo is not checked.
module regjob_ack_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [DATA_W-1:0] ak_data,
    input  logic              ak_valid,
    input  logic              ak_first,
    input  logic              ak_last,
    output logic              ak_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              err,
    output logic              fin
);
    logic armed;

    assign ak_ready = armed;
    // Footer taken in this cycle.
    assign fin      = ak_valid & armed & ak_last;

    // Arming, data capture and completion reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            rd_data <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (arm) begin
                armed <= 1'b1;
            end
            if (ak_valid && armed) begin
                if (ak_last) begin
                    armed <= 1'b0;
                    done  <= 1'b1;
                    err   <= ak_data[0];
                end else if (!ak_first) begin
                    rd_data <= ak_data;
                end
            end
        end
    end

    // Completion is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A new job only arms an idle parser.
    p_arm_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !armed);

    // After the footer the parser stops taking beats.
    p_drop_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !ak_ready && done);

endmodule

// File: rtl/regjob_master.sv
// Register job master: turns a command pulse into a framed request, then
// collects the framed acknowledge and reports done, read data and error.
// Assumes DATA_W = ADDR_W + command width; one job at a time.
module regjob_master #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              err,
    output logic [DATA_W-1:0] rq_data,
    output logic              rq_valid,
    output logic              rq_first,
    output logic              rq_last,
    input  logic              rq_ready,
    input  logic [DATA_W-1:0] ak_data,
    input  logic              ak_valid,
    input  logic              ak_first,
    input  logic              ak_last,
    output logic              ak_ready
);
    import regjob_pkg::*;

    localparam int CMD_W = DATA_W - ADDR_W;
    localparam logic [CMD_W-1:0] CODE_RD = CMD_W'(CMD_READ);
    localparam logic [CMD_W-1:0] CODE_WR = CMD_W'(CMD_WRITE);

    logic              go_ok;
    logic              sent;
    logic              fin;
    logic [DATA_W-1:0] hdr;

    // A command is taken only while no job is in flight.
    assign go_ok = cmd_go & !busy;
    assign hdr   = {cmd_addr, (cmd_wr ? CODE_WR : CODE_RD)};

    // Job-in-flight flag: set on an accepted command, cleared by the footer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (go_ok) begin
            busy <= 1'b1;
        end else if (fin) begin
            busy <= 1'b0;
        end
    end

    regjob_req_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (go_ok),
        .is_wr    (cmd_wr),
        .hdr      (hdr),
        .wdata    (cmd_wdata),
        .rq_data  (rq_data),
        .rq_valid (rq_valid),
        .rq_first (rq_first),
        .rq_last  (rq_last),
        .rq_ready (rq_ready),
        .sent     (sent)
    );

    regjob_ack_rx #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (sent),
        .ak_data  (ak_data),
        .ak_valid (ak_valid),
        .ak_first (ak_first),
        .ak_last  (ak_last),
        .ak_ready (ak_ready),
        .rd_data  (rd_data),
        .done     (done),
        .err      (err),
        .fin      (fin)
    );

    // Request and acknowledge phases never overlap.
    p_phase_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rq_valid && ak_ready));

    // Acknowledge beats are only taken during a job.
    p_ack_in_job_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ak_ready |-> busy);

    // Completion coincides with the end of the job.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // A job starts with its header beat.
    p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> rq_valid && rq_first);

    // A command during a job does not disturb the beat in flight.
    p_go_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_go && rq_valid && !rq_ready |=> $stable(rq_data));

endmodule

// File: tb/regjob_master_tb.sv
module regjob_master_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_go = 1'b0, cmd_wr = 1'b0;
    logic [3:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       busy, done, err;
    logic [7:0] rd_data, rq_data;
    logic       rq_valid, rq_first, rq_last;
    logic       rq_ready = 1'b0;
    logic [7:0] ak_data = '0;
    logic       ak_valid = 1'b0, ak_first = 1'b0, ak_last = 1'b0;
    logic       ak_ready;
    int         n_tests = 0, n_fail = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    regjob_master u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_wr(cmd_wr),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .err(err), .rq_data(rq_data), .rq_valid(rq_valid),
        .rq_first(rq_first), .rq_last(rq_last), .rq_ready(rq_ready),
        .ak_data(ak_data), .ak_valid(ak_valid), .ak_first(ak_first),
        .ak_last(ak_last), .ak_ready(ak_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Start a job and check the cycle after the pulse (R10).
    task automatic start_job(input logic wr, input logic [3:0] a, input logic [7:0] wd);
        @(negedge clk);
        cmd_go = 1'b1; cmd_wr = wr; cmd_addr = a; cmd_wdata = wd;
        @(negedge clk);
        cmd_go = 1'b0;
        chk("R10 busy", busy, 1);
        chk("R10 header valid", rq_valid, 1);
    endtask

    // Hold a request beat for some cycles, then accept it.
    task automatic take_beat(input int stall, input logic [7:0] exp_d,
                             input logic exp_f, input logic exp_l);
        chk("R2 beat data", rq_data, exp_d);
        chk("R3/R4 first", rq_first, exp_f);
        chk("R3/R4 last", rq_last, exp_l);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk("R5 held valid", rq_valid, 1);
            chk("R5 held data", rq_data, exp_d);
            chk("R5 held flags", {rq_first, rq_last}, {exp_f, exp_l});
            chk("R6 no ack ready", ak_ready, 0);
        end
        rq_ready = 1'b1;
        @(negedge clk);
        rq_ready = 1'b0;
    endtask

    task automatic ack_beat(input logic f, input logic l, input logic [7:0] d, input int gap);
        for (int i = 0; i < gap; i++) @(negedge clk);
        ak_valid = 1'b1; ak_first = f; ak_last = l; ak_data = d;
        @(negedge clk);
        ak_valid = 1'b0; ak_first = 1'b0; ak_last = 1'b0; ak_data = '0;
    endtask

    // Footer and completion checks (R8, R6).
    task automatic finish_job(input logic [7:0] footer, input int gap);
        chk("R6 ready before footer", ak_ready, 1);
        ack_beat(1'b0, 1'b1, footer, gap);
        chk("R8 done", done, 1);
        chk("R8 busy low", busy, 0);
        chk("R8 err", err, footer[0]);
        chk("R6 ready dropped", ak_ready, 0);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
        chk("R1 rd_data", rd_data, 0); chk("R1 rq_valid", rq_valid, 0);
        chk("R1 rq flags", {rq_first, rq_last}, 0); chk("R1 rq_data", rq_data, 0);
        chk("R1 ak_ready", ak_ready, 0);
    endtask

    task automatic test_read(input logic [3:0] a, input logic [7:0] val,
                             input logic [7:0] footer, input int stall);
        start_job(1'b0, a, 8'h00);
        take_beat(stall, {a, 4'h0}, 1'b1, 1'b1);
        chk("R3 single beat", rq_valid, 0);
        chk("R6 ready after request", ak_ready, 1);
        ack_beat(1'b1, 1'b0, {a, 4'h0}, 1);
        chk("R6 ready mid frame", ak_ready, 1);
        chk("R8 no early done", done, 0);
        ack_beat(1'b0, 1'b0, val, 2);
        chk("R7 read data", rd_data, val);
        finish_job(footer, 0);
    endtask

    task automatic test_write(input logic [3:0] a, input logic [7:0] wd,
                              input logic [7:0] footer, input logic [7:0] rd_keep);
        start_job(1'b1, a, wd);
        take_beat(1, {a, 4'h1}, 1'b1, 1'b0);
        chk("R4 second beat valid", rq_valid, 1);
        take_beat(2, wd, 1'b0, 1'b1);
        chk("R4 frame closed", rq_valid, 0);
        ack_beat(1'b1, 1'b0, {a, 4'h1}, 0);
        finish_job(footer, 1);
        chk("R7 rd_data unchanged by write", rd_data, rd_keep);
    endtask

    task automatic test_busy_ignore();
        start_job(1'b0, 4'h2, 8'h00);
        cmd_go = 1'b1; cmd_wr = 1'b1; cmd_addr = 4'h7; cmd_wdata = 8'hEE;
        @(negedge clk);
        cmd_go = 1'b0;
        chk("R9 header kept", rq_data, 8'h20);
        take_beat(1, 8'h20, 1'b1, 1'b1);
        ack_beat(1'b1, 1'b0, 8'h20, 0);
        ack_beat(1'b0, 1'b0, 8'h5A, 0);
        chk("R7 read data", rd_data, 8'h5A);
        finish_job(8'h00, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 no phantom request", rq_valid, 0);
            chk("R9 stays idle", busy, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_read(4'h3, 8'hA5, 8'h00, 2);
        test_write(4'h5, 8'h3C, 8'h00, 8'hA5);
        test_read(4'h9, 8'h00, 8'h01, 0);
        test_write(4'h0, 8'h77, 8'h00, 8'h00);
        test_busy_ignore();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule